// File: doc/BRIEF.md
# Transmit Data Chunk Framer

This block takes one outgoing Ethernet frame, presented as a byte stream whose length is announced up front, and sends it to a 10 Mb/s single-pair MAC-PHY over SPI. The frame is cut into fixed 64-byte payload slices. Each slice goes out behind a 32-bit data header inside its own chip-select window. The final slice is filled out with zero bytes. The header marks the slice that opens the frame, the slice that closes it, and the offset of the closing byte. It also carries an odd-parity bit.

Before any byte moves, the block compares the number of slices the frame needs with the transmit credit count taken from a buffer status word. If the credits fall short, or the length is out of range, the frame is dropped at once. While each window is clocked, the block records the last 32 bits shifted in on MISO as the receive footer. It raises a pending flag when that footer reports receive chunks waiting. The host then knows it should start a receive transfer.

Top module: `tx_chunk_framer`

## Requirements
- R1: Every chunk is one window with cs_no low that carries exactly 544 SCLK pulses (4 header bytes then 64 payload bytes), each byte MSB first. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge.
- R2: The header is sent big-endian. Bit 31 (data, not control) and bit 21 (data valid) are 1 in every chunk. Bits not named in R3 to R5 are 0.
- R3: Header bit 20 (start mark) is 1 only in the first chunk of a frame.
- R4: Header bit 14 (end mark) is 1 only in the last chunk. In that chunk, bits 13:8 hold the count of frame bytes in that chunk minus 1. These bits are 0 in every other chunk.
- R5: Header bit 0 is set so that the 32-bit header holds an odd number of ones.
- R6: Payload bytes carry the frame bytes in input order. Every payload byte after the last frame byte is 0x00.
- R7: A frame of L bytes is sent as ceil(L/64) chunks.
- R8: On start_i the frame is sent only if 1 <= len_i <= 1518 and bufsts_i[15:8] >= ceil(len_i/64). Otherwise drop_o pulses for one cycle, no chip-select window occurs and no byte is taken.
- R9: byte_ready_o is high only while cs_no is low, after the 4 header bytes of a chunk, and while frame bytes remain. It is low during header bytes and padding.
- R10: After each chunk, footer_o holds the last 32 bits received in that window, first bit in bit 31. rx_pend_o is 1 exactly when footer bits 28:24 are nonzero.
- R11: done_o pulses once after the final chunk's window closes. busy_o is high from an accepted start to that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a new frame |
| len_i | input | 11 | Frame length in bytes, sampled with start_i |
| bufsts_i | input | 32 | Buffer status word; bits 15:8 give transmit credits |
| byte_i | input | 8 | Frame byte |
| byte_valid_i | input | 1 | byte_i is valid |
| byte_ready_o | output | 1 | Block takes byte_i this cycle if valid |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| busy_o | output | 1 | A frame is being sent |
| done_o | output | 1 | One-cycle pulse when a frame is finished |
| drop_o | output | 1 | One-cycle pulse when a frame is refused |
| footer_o | output | 32 | Footer of the most recent chunk |
| rx_pend_o | output | 1 | Receive chunks pending per last footer |

## Verification
On every cycle, the assertions check that header parity is odd while busy, that SCLK stays low and no shift runs outside a chip-select window, and that no byte is loaded into the shifter while a shift is in progress. They also check that byte_ready_o never rises during header slots, that a drop leaves the block idle, and that completion comes only with no frame bytes left. The bench scenarios are the only place where the outcomes show. These are: the header contents per chunk, the chunk count against length, zero padding, the credit boundary at exactly enough and one short, the 1-byte, 64-byte, 65-byte and 1518-byte lengths, and footer capture with the pending flag in both states.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int HDR_BYTES  = 4;
  localparam int HB_DNC     = 31;
  localparam int HB_DV      = 21;
  localparam int HB_SV      = 20;
  localparam int HB_EV      = 14;
  localparam int HB_EBO_LSB = 8;
  localparam int HB_P       = 0;
  localparam int FT_RCA_MSB = 28;
  localparam int FT_RCA_LSB = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP} tcf_state_e;

  function automatic logic [31:0] make_hdr(input logic sv, input logic ev, input logic [5:0] ebo);
    logic [31:0] h;
    h = '0;
    h[HB_DNC] = 1'b1;
    h[HB_DV]  = 1'b1;
    h[HB_SV]  = sv;
    h[HB_EV]  = ev;
    h[HB_EBO_LSB +: 6] = ebo;
    h[HB_P]   = ~(^h[31:1]);
    return h;
  endfunction
endpackage

// File: rtl/tcf_credit_chk.sv
module tcf_credit_chk #(
  parameter int PAYLOAD_BYTES = 64,
  parameter int MAX_LEN       = 1518,
  parameter int LEN_W         = 11,
  parameter int CRED_W        = 8
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CRED_W-1:0] credits_i,
  output logic              ok_o
);
  localparam int EBO_W  = $clog2(PAYLOAD_BYTES);
  localparam int NEED_W = LEN_W + 1 - EBO_W;

  logic [LEN_W:0]    sum_w;
  logic [NEED_W-1:0] need_w;
  logic [31:0]       need32, cred32;

  always_comb begin
    sum_w  = {1'b0, len_i} + (LEN_W+1)'(PAYLOAD_BYTES - 1);
    need_w = sum_w[LEN_W:EBO_W];
    need32 = 32'(need_w);
    cred32 = 32'(credits_i);
    ok_o   = (len_i != '0) && (len_i <= LEN_W'(MAX_LEN)) && (need32 <= cred32);
  end
endmodule

// File: rtl/tcf_hdr_gen.sv
module tcf_hdr_gen
  import tcf_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64,
  parameter int LEN_W         = 11
) (
  input  logic             first_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [31:0]      hdr_o
);
  logic             ev_w;
  logic [LEN_W-1:0] rm1_w;
  logic [5:0]       ebo_w;

  always_comb begin
    ev_w  = rem_i <= LEN_W'(PAYLOAD_BYTES);
    rm1_w = rem_i - 1'b1;
    ebo_w = ev_w ? rm1_w[5:0] : 6'd0;
    hdr_o = make_hdr(first_i, ev_w, ebo_w);
  end
endmodule

// File: rtl/tcf_spi_shift.sv
module tcf_spi_shift (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [7:0]  byte_i,
  input  logic        miso_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic [31:0] rx_o
);
  logic [3:0]  cnt_q;
  logic [7:0]  sh_q;
  logic        act_q;
  logic [31:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
      rx_q  <= '0;
    end else if (load_i) begin
      sh_q  <= byte_i;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q[0]) sh_q <= {sh_q[6:0], 1'b0};
      else          rx_q <= {rx_q[30:0], miso_i};  // sample as SCLK rises
      if (cnt_q == 4'd15) act_q <= 1'b0;
    end
  end

  assign busy_o = act_q;
  assign done_o = act_q && (cnt_q == 4'd15);
  assign sclk_o = act_q && cnt_q[0];
  assign mosi_o = sh_q[7];
  assign rx_o   = rx_q;

  p_no_reload_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !act_q);
endmodule

// File: rtl/tx_chunk_framer.sv
module tx_chunk_framer
  import tcf_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64,
  parameter int MAX_LEN       = 1518,
  parameter int CRED_W        = 8,
  parameter int CRED_LSB      = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [10:0] len_i,
  input  logic [31:0] bufsts_i,
  input  logic [7:0]  byte_i,
  input  logic        byte_valid_i,
  output logic        byte_ready_o,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        drop_o,
  output logic [31:0] footer_o,
  output logic        rx_pend_o
);
  localparam int LEN_W     = 11;
  localparam int WIN_BYTES = HDR_BYTES + PAYLOAD_BYTES;
  localparam int SLOT_W    = $clog2(WIN_BYTES);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WIN_BYTES - 1);

  tcf_state_e       state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LEN_W-1:0] rem_q, chunk_rem_q;
  logic             first_q, done_q, drop_q, pend_q;
  logic [31:0]      foot_q, hdr_w, rx_w;
  logic             ok_w, is_hdr_w, have_w, load_w, sh_busy_w, sh_done_w;
  logic [1:0]       hsel_w;
  logic [7:0]       load_byte_w;

  tcf_credit_chk #(.PAYLOAD_BYTES(PAYLOAD_BYTES), .MAX_LEN(MAX_LEN),
                   .LEN_W(LEN_W), .CRED_W(CRED_W)) u_cred (
    .len_i(len_i), .credits_i(bufsts_i[CRED_LSB +: CRED_W]), .ok_o(ok_w));

  tcf_hdr_gen #(.PAYLOAD_BYTES(PAYLOAD_BYTES), .LEN_W(LEN_W)) u_hdr (
    .first_i(first_q), .rem_i(chunk_rem_q), .hdr_o(hdr_w));

  tcf_spi_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_w), .byte_i(load_byte_w),
    .miso_i(miso_i), .busy_o(sh_busy_w), .done_o(sh_done_w),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .rx_o(rx_w));

  always_comb begin
    is_hdr_w     = slot_q < SLOT_W'(HDR_BYTES);
    have_w       = rem_q != '0;
    hsel_w       = 2'(HDR_BYTES - 1) - slot_q[1:0];
    byte_ready_o = (state_q == ST_LOAD) && !is_hdr_w && have_w;
    load_w       = (state_q == ST_LOAD) && (is_hdr_w || !have_w || byte_valid_i);
    if (is_hdr_w)    load_byte_w = hdr_w[8*hsel_w +: 8];
    else if (have_w) load_byte_w = byte_i;
    else             load_byte_w = 8'h00;  // pad
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      slot_q      <= '0;
      rem_q       <= '0;
      chunk_rem_q <= '0;
      first_q     <= 1'b0;
      done_q      <= 1'b0;
      drop_q      <= 1'b0;
      pend_q      <= 1'b0;
      foot_q      <= '0;
    end else begin
      done_q <= 1'b0;
      drop_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (ok_w) begin
            rem_q       <= len_i;
            chunk_rem_q <= len_i;
            first_q     <= 1'b1;
            slot_q      <= '0;
            state_q     <= ST_LOAD;
          end else begin
            drop_q <= 1'b1;
          end
        end
        ST_LOAD: if (load_w) begin
          state_q <= ST_SHIFT;
          if (byte_ready_o) rem_q <= rem_q - 1'b1;
        end
        ST_SHIFT: if (sh_done_w) begin
          if (slot_q == LAST_SLOT) begin
            foot_q  <= rx_w;
            pend_q  <= |rx_w[FT_RCA_MSB:FT_RCA_LSB];
            state_q <= ST_GAP;
          end else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        ST_GAP: begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            first_q     <= 1'b0;
            chunk_rem_q <= rem_q;
            slot_q      <= '0;
            state_q     <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = !((state_q == ST_LOAD) || (state_q == ST_SHIFT));
  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = done_q;
  assign drop_o    = drop_q;
  assign footer_o  = foot_q;
  assign rx_pend_o = pend_q;

  p_shift_in_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy_w |-> !cs_no);
  p_sclk_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_hdr_odd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (^hdr_w) == 1'b1);
  p_no_ready_hdr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (slot_q >= SLOT_W'(HDR_BYTES)) && !cs_no);
  p_drop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !busy_o);
  p_done_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rem_q == '0) && !busy_o);
endmodule

// File: tb/tx_chunk_framer_tb_top.sv
module tx_chunk_framer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [10:0] len = '0;
  logic [31:0] bufsts = '0;
  logic [7:0] bi = '0;
  logic bv = 1'b0;
  logic miso = 1'b0;
  logic byte_ready, sclk, cs_n, mosi, busy, done, drop, rx_pend;
  logic [31:0] footer;

  int checks = 0, fails = 0;
  int nbytes = 0, winbits = 0, win_err = 0, nchunks = 0, kbit = 0;
  int fed = 0, cur_len = 0, rdy_err = 0, drop_seen = 0;
  bit mon_en = 1'b0;
  logic [7:0] sh8 = '0;
  logic [7:0] cap [0:2047];
  logic [31:0] cur_foot = '0;

  always #10 clk = ~clk;

  tx_chunk_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .bufsts_i(bufsts),
    .byte_i(bi), .byte_valid_i(bv), .byte_ready_o(byte_ready), .sclk_o(sclk),
    .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso), .busy_o(busy), .done_o(done),
    .drop_o(drop), .footer_o(footer), .rx_pend_o(rx_pend));

  function automatic logic [31:0] foot_of(input int c);
    return (c % 2 == 1) ? 32'h0300_0012 : 32'h00FF_FF7E;
  endfunction

  function automatic logic miso_bit(input int k);
    logic [7:0] fill;
    fill = 8'hC3;
    if (k < 512) return fill[7 - (k % 8)];
    if (k < 544) return cur_foot[31 - (k - 512)];
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_hdr(input int c, input int n, input int l);
    logic [31:0] h;
    h = '0;
    h[31] = 1'b1;
    h[21] = 1'b1;
    h[20] = (c == 0);
    if (c == n - 1) begin
      h[14] = 1'b1;
      h[13:8] = 6'(l - 64 * c - 1);
    end
    h[0] = ~(^h[31:1]);
    return h;
  endfunction

  // slave model
  always @(negedge cs_n) if (mon_en) begin
    nchunks++;
    winbits = 0;
    kbit = 0;
    cur_foot = foot_of(nchunks - 1);
    miso = miso_bit(0);
  end
  always @(posedge cs_n) if (mon_en && winbits != 544) win_err++;
  always @(posedge sclk) if (mon_en) begin
    sh8 = {sh8[6:0], mosi};
    winbits++;
    if (winbits % 8 == 0 && nbytes < 2048) begin
      cap[nbytes] = sh8;
      nbytes++;
    end
  end
  always @(negedge sclk) if (mon_en) begin
    kbit++;
    miso = miso_bit(kbit);
  end
  always @(negedge clk) if (mon_en) begin
    if (byte_ready && (cs_n || winbits < 32 || fed >= cur_len)) rdy_err++;
    if (drop) drop_seen++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon(input int l);
    nbytes = 0; win_err = 0; nchunks = 0; fed = 0; rdy_err = 0; drop_seen = 0;
    cur_len = l;
  endtask

  task automatic feed(input int l, input int seed);
    for (int i = 0; i < l; i++) begin
      bi = 8'(seed + i);
      bv = 1'b1;
      @(negedge clk);
      while (!byte_ready) @(negedge clk);
      @(posedge clk);
      #1;
      fed++;
    end
    bv = 1'b0;
  endtask

  task automatic pulse_start(input int l, input int cred);
    len = 11'(l);
    bufsts = (32'(cred) << 8) | 32'h5A00_00A5;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic test_send(input int l, input int cred, input int seed);
    int n, bad;
    logic [31:0] h, eh, ef;
    logic [7:0] eb;
    n = (l + 63) / 64;
    clear_mon(l);
    pulse_start(l, cred);
    fork
      feed(l, seed);
      begin
        while (!done) @(negedge clk);
      end
    join
    @(negedge clk);
    chk(nchunks == n, "R7 chunk count", 32'(nchunks), 32'(n));
    chk(win_err == 0, "R1 window length", 32'(win_err), 0);
    chk(drop_seen == 0, "R8 no drop when credits cover", 32'(drop_seen), 0);
    chk(rdy_err == 0, "R9 ready only in payload", 32'(rdy_err), 0);
    chk(!busy, "R11 idle after done", 32'(busy), 0);
    for (int c = 0; c < n && c < nchunks; c++) begin
      h = {cap[c*68], cap[c*68+1], cap[c*68+2], cap[c*68+3]};
      eh = exp_hdr(c, n, l);
      chk(h[31] && h[21] && (h[30:22] == 0) && (h[19:15] == 0) && (h[7:1] == 0),
          "R2 header fixed bits", h, eh);
      chk(h[20] == eh[20], "R3 start mark", h, eh);
      chk(h[14:8] == eh[14:8], "R4 end mark and offset", h, eh);
      chk(^h == 1'b1, "R5 odd parity", h, eh);
    end
    bad = 0;
    for (int c = 0; c < n && c < nchunks; c++)
      for (int j = 4; j < 68; j++) begin
        eb = (c*64 + j - 4 < l) ? 8'(seed + c*64 + j - 4) : 8'h00;
        if (cap[c*68+j] !== eb) bad++;
      end
    chk(bad == 0, "R6 payload and zero pad", 32'(bad), 0);
    ef = foot_of(n - 1);
    chk(footer == ef, "R10 footer capture", footer, ef);
    chk(rx_pend == (|ef[28:24]), "R10 pending flag", 32'(rx_pend), 32'(|ef[28:24]));
  endtask

  task automatic test_drop(input int l, input int cred, input string why);
    clear_mon(0);
    bv = 1'b1;
    bi = 8'h77;
    pulse_start(l, cred);
    repeat (20) @(negedge clk);
    bv = 1'b0;
    chk(drop_seen == 1, {"R8 drop pulse ", why}, 32'(drop_seen), 1);
    chk(nchunks == 0, {"R8 no window ", why}, 32'(nchunks), 0);
    chk(rdy_err == 0, {"R8 no byte taken ", why}, 32'(rdy_err), 0);
    chk(!busy, {"R11 stays idle ", why}, 32'(busy), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !byte_ready && !rx_pend && !done && !drop,
        "R1 R11 reset state", {25'd0, cs_n, sclk, busy, byte_ready, rx_pend, done, drop}, 32'h40);
    mon_en = 1'b1;
    test_send(1, 1, 8'h10);
    test_send(64, 1, 8'h20);
    test_send(65, 2, 8'h30);
    test_send(200, 4, 8'h40);
    test_drop(200, 3, "short credit");
    test_drop(0, 10, "zero length");
    test_drop(1519, 255, "too long");
    test_send(1518, 24, 8'h50);
    finish_run();
  end
endmodule